// File: doc/BRIEF.md
# Trace filter register access guard

This block decides, in the same cycle as the request, what happens to a coprocessor-style read or write of a trace filter control register. It looks at the current privilege level (0 to 3), at whether the hypervisor level is enabled and runs 64-bit or 32-bit, and at whether a monitor level exists and runs 64-bit or 32-bit. It also takes the security state, whether the core is already in monitor mode, a hypervisor group trap bit, and two trace trap bits, one from the hypervisor configuration and one from the monitor configuration. From these it yields one verdict. The access is either allowed, undefined, or trapped in one of four forms, and the form depends on the width of the level that handles the trap.

Alongside the verdict the block gives a 6-bit syndrome class and a write strobe. It also holds the register itself. Bits outside a writable mask are stored as zero, and the register loads only when a write is allowed. Taking the exception is left to the surrounding pipeline.

Top module: `sag_access_guard`

## Requirements
- R1: At level 0 (`cur_lvl` = 0) every access is undefined, whatever the other inputs.
- R2: At level 1, a set group trap bit with the hypervisor enabled wins over every other check. It yields the 64-bit level-2 trap when `hyp_is64` is 1 and the hypervisor trap otherwise. With the hypervisor disabled the group trap bit has no effect.
- R3: At level 1, when the group trap does not fire, a secure access (`nonsecure` = 0) is undefined, even if trace trap bits are set.
- R4: At level 1, in non-secure state, the hypervisor trace trap bit with the hypervisor enabled comes next. It is routed by `hyp_is64` in the same way as R2, and it has no effect while the hypervisor is disabled.
- R5: At level 1, the monitor trace trap bit fires last, and only when the monitor is present. A 64-bit monitor gives the 64-bit level-3 trap. A 32-bit monitor gives the monitor trap, unless `in_mon_mode` is 1, in which case the access is allowed.
- R6: At level 2, only the monitor trace trap applies, routed as in R5 but with no monitor-mode exemption. The group trap, the hypervisor trace trap and the security state have no effect, and otherwise the access is allowed.
- R7: At level 3, a secure access is undefined and a non-secure one is allowed. The trap bits have no effect.
- R8: `verdict` is one-hot and valid in the cycle of the inputs. Bit 0 is allow, bit 1 undefined, bit 2 the 64-bit level-2 trap, bit 3 the hypervisor trap, bit 4 the 64-bit level-3 trap, and bit 5 the monitor trap.
- R9: `syndrome` is 0x03 for the 64-bit level-2 trap, the hypervisor trap and the 64-bit level-3 trap. It is 0x00 for allow, undefined and the monitor trap.
- R10: `reg_wr_en` is high exactly when `acc_req`, `acc_write` and allow are all high. The register takes `acc_wdata` masked by `WR_MASK` at the next clock edge and holds otherwise, so reads, idle cycles and refused writes leave it unchanged.
- R11: After reset `reg_value` is `RST_VAL` masked by `WR_MASK` (zero by default). Bits outside `WR_MASK` always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held register |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | DATA_W | Write data |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| hyp_on | input | 1 | Hypervisor level enabled in the current state |
| hyp_is64 | input | 1 | Hypervisor level runs 64-bit |
| mon_present | input | 1 | Monitor level implemented |
| mon_is64 | input | 1 | Monitor level runs 64-bit |
| nonsecure | input | 1 | 1 = non-secure state |
| in_mon_mode | input | 1 | Core is currently in monitor mode |
| hyp_grp_trap | input | 1 | Hypervisor group trap bit |
| hyp_trc_trap | input | 1 | Hypervisor trace register trap bit |
| mon_trc_trap | input | 1 | Monitor trace register trap bit |
| verdict | output | 6 | One-hot access verdict (see R8) |
| syndrome | output | 6 | Syndrome class of the verdict |
| reg_wr_en | output | 1 | Write strobe for the register |
| reg_value | output | DATA_W | Current register contents |

## Verification
The bench builds the block with its defaults: a 32-bit register, `WR_MASK` of 0x63 and a zero reset value. The mask holds two separated writable groups with reserved bits between them and above them. An all-ones write therefore shows both the stored pattern and the forced zeros in one read-back. The table covers every level against each trap source, with the width and presence flags varied. Directed writes then show that refused, read and idle accesses leave the register unchanged.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        LVL_USR = 2'd0,
        LVL_KRN = 2'd1,
        LVL_HYP = 2'd2,
        LVL_MON = 2'd3
    } lvl_e;

    typedef enum logic [5:0] {
        V_ALLOW    = 6'b000001,
        V_UNDEF    = 6'b000010,
        V_TRAP_L2W = 6'b000100,
        V_TRAP_HYP = 6'b001000,
        V_TRAP_L3W = 6'b010000,
        V_TRAP_MON = 6'b100000
    } verdict_e;

    localparam int          SYN_W    = 6;
    localparam logic [5:0]  SYN_TRAP = 6'h03;

endpackage

// File: rtl/sag_route.sv
module sag_route
    import sag_pkg::*;
#(
    parameter verdict_e WIDE_V   = V_TRAP_L2W,
    parameter verdict_e NARROW_V = V_TRAP_HYP
) (
    input  logic     fire,
    input  logic     is64,
    output logic     hit,
    output verdict_e verdict
);

    assign hit     = fire;
    assign verdict = is64 ? WIDE_V : NARROW_V;

endmodule

// File: rtl/sag_prio.sv
module sag_prio
    import sag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_e     lvl,
    input  logic     hyp_on,
    input  logic     hyp_is64,
    input  logic     mon_present,
    input  logic     mon_is64,
    input  logic     nonsecure,
    input  logic     in_mon_mode,
    input  logic     hyp_grp_trap,
    input  logic     hyp_trc_trap,
    input  logic     mon_trc_trap,
    output verdict_e verdict
);

    logic     grp_hit, htrc_hit, mtrc_hit;
    verdict_e grp_v, htrc_v, mtrc_v;
    logic     mon_exempt;

    sag_route #(.WIDE_V(V_TRAP_L2W), .NARROW_V(V_TRAP_HYP)) u_grp (
        .fire    (hyp_on & hyp_grp_trap),
        .is64    (hyp_is64),
        .hit     (grp_hit),
        .verdict (grp_v)
    );

    sag_route #(.WIDE_V(V_TRAP_L2W), .NARROW_V(V_TRAP_HYP)) u_htrc (
        .fire    (hyp_on & hyp_trc_trap),
        .is64    (hyp_is64),
        .hit     (htrc_hit),
        .verdict (htrc_v)
    );

    sag_route #(.WIDE_V(V_TRAP_L3W), .NARROW_V(V_TRAP_MON)) u_mtrc (
        .fire    (mon_present & mon_trc_trap),
        .is64    (mon_is64),
        .hit     (mtrc_hit),
        .verdict (mtrc_v)
    );

    // a 32-bit monitor trap is skipped at level 1 when already in monitor mode
    assign mon_exempt = (mtrc_v == V_TRAP_MON) && in_mon_mode;

    always_comb begin
        verdict = V_ALLOW;
        unique case (lvl)
            LVL_USR: verdict = V_UNDEF;
            LVL_KRN: begin
                if (grp_hit)                       verdict = grp_v;
                else if (!nonsecure)               verdict = V_UNDEF;
                else if (htrc_hit)                 verdict = htrc_v;
                else if (mtrc_hit && !mon_exempt)  verdict = mtrc_v;
                else                               verdict = V_ALLOW;
            end
            LVL_HYP: begin
                if (mtrc_hit) verdict = mtrc_v;
                else          verdict = V_ALLOW;
            end
            LVL_MON: begin
                if (!nonsecure) verdict = V_UNDEF;
                else            verdict = V_ALLOW;
            end
        endcase
    end

    assert_l0_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_USR) |-> (verdict == V_UNDEF));

    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(verdict) == 1);

    assert_l2_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_HYP && !(mon_present && mon_trc_trap)) |-> (verdict == V_ALLOW));

    assert_l3_ns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_MON && nonsecure) |-> (verdict == V_ALLOW));

    assert_l1_secure_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_KRN && !nonsecure && !(hyp_on && hyp_grp_trap)) |-> (verdict == V_UNDEF));

endmodule

// File: rtl/sag_hold.sv
module sag_hold #(
    parameter int              DATA_W  = 32,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h0000_0063,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] RST_MASKED = RST_VAL & WR_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_MASKED;
        else if (wr_en) q <= wdata & WR_MASK;
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == ($past(wdata) & WR_MASK)));

    assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~WR_MASK) == '0);

endmodule

// File: rtl/sag_access_guard.sv
module sag_access_guard
    import sag_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h0000_0063,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        cur_lvl,
    input  logic              hyp_on,
    input  logic              hyp_is64,
    input  logic              mon_present,
    input  logic              mon_is64,
    input  logic              nonsecure,
    input  logic              in_mon_mode,
    input  logic              hyp_grp_trap,
    input  logic              hyp_trc_trap,
    input  logic              mon_trc_trap,
    output logic [5:0]        verdict,
    output logic [SYN_W-1:0]  syndrome,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_value
);

    verdict_e vd;

    sag_prio u_prio (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl          (lvl_e'(cur_lvl)),
        .hyp_on       (hyp_on),
        .hyp_is64     (hyp_is64),
        .mon_present  (mon_present),
        .mon_is64     (mon_is64),
        .nonsecure    (nonsecure),
        .in_mon_mode  (in_mon_mode),
        .hyp_grp_trap (hyp_grp_trap),
        .hyp_trc_trap (hyp_trc_trap),
        .mon_trc_trap (mon_trc_trap),
        .verdict      (vd)
    );

    always_comb begin
        unique case (vd)
            V_TRAP_L2W, V_TRAP_HYP, V_TRAP_L3W: syndrome = SYN_TRAP;
            default:                            syndrome = '0;
        endcase
    end

    assign verdict   = vd;
    assign reg_wr_en = acc_req & acc_write & (vd == V_ALLOW);

    sag_hold #(.DATA_W(DATA_W), .WR_MASK(WR_MASK), .RST_VAL(RST_VAL)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (acc_wdata),
        .q     (reg_value)
    );

    assert_syn_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict[0] | verdict[1] | verdict[5]) |-> (syndrome == '0));

    assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (acc_req && acc_write && verdict[0]));

endmodule

// File: tb/sag_access_guard_tb.sv
module sag_access_guard_tb;

    localparam int DW = 32;
    localparam logic [5:0] ALW = 6'b000001, UND = 6'b000010, T2 = 6'b000100,
                           HY  = 6'b001000, T3  = 6'b010000, MO = 6'b100000;
    localparam int NV = 22;

    // {lvl[1:0], hyp_on, hyp_is64, mon_present, mon_is64, nonsecure, in_mon_mode,
    //  grp_trap, hyp_trc, mon_trc, expected[5:0]}
    localparam logic [16:0] VEC [NV] = '{
        {11'b00_111_111_111, UND},
        {11'b00_000_000_000, UND},
        {11'b01_110_000_100, T2},
        {11'b01_100_010_100, HY},
        {11'b01_000_010_100, ALW},
        {11'b01_000_000_100, UND},
        {11'b01_111_100_011, UND},
        {11'b01_111_110_011, T2},
        {11'b01_100_010_010, HY},
        {11'b01_000_010_010, ALW},
        {11'b01_001_110_001, T3},
        {11'b01_001_010_001, MO},
        {11'b01_001_011_001, ALW},
        {11'b01_000_110_001, ALW},
        {11'b01_111_110_000, ALW},
        {11'b10_111_100_110, ALW},
        {11'b10_001_100_001, T3},
        {11'b10_001_011_001, MO},
        {11'b10_000_010_001, ALW},
        {11'b11_111_100_111, UND},
        {11'b11_111_110_111, ALW},
        {11'b11_000_011_000, ALW}
    };
    localparam string TAGS [NV] = '{
        "R1", "R1", "R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4", "R5",
        "R5", "R5", "R5", "R5", "R6", "R6", "R6", "R6", "R7", "R7", "R7"
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0, acc_write = 1'b0;
    logic [DW-1:0] acc_wdata = '0;
    logic [1:0] cur_lvl = 2'd0;
    logic hyp_on = 0, hyp_is64 = 0, mon_present = 0, mon_is64 = 0, nonsecure = 0;
    logic in_mon_mode = 0, hyp_grp_trap = 0, hyp_trc_trap = 0, mon_trc_trap = 0;
    logic [5:0] verdict, syndrome;
    logic reg_wr_en;
    logic [DW-1:0] reg_value;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    sag_access_guard u_dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .cur_lvl(cur_lvl), .hyp_on(hyp_on), .hyp_is64(hyp_is64),
        .mon_present(mon_present), .mon_is64(mon_is64), .nonsecure(nonsecure),
        .in_mon_mode(in_mon_mode), .hyp_grp_trap(hyp_grp_trap),
        .hyp_trc_trap(hyp_trc_trap), .mon_trc_trap(mon_trc_trap),
        .verdict(verdict), .syndrome(syndrome), .reg_wr_en(reg_wr_en),
        .reg_value(reg_value)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [10:0] s);
        {cur_lvl, hyp_on, hyp_is64, mon_present, mon_is64, nonsecure, in_mon_mode,
         hyp_grp_trap, hyp_trc_trap, mon_trc_trap} = s;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [5:0] e;
        // reset state (R11, R1)
        #2;
        chk("R11 reset value", reg_value, 32'h0);
        chk("R1 reset-time verdict", {26'd0, verdict}, {26'd0, UND});
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: reads only, so the register stays untouched
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_ctx(VEC[i][16:6]);
            acc_req = 1'b1; acc_write = 1'b0;
            #1;
            e = VEC[i][5:0];
            chk({TAGS[i], " R8 verdict"}, {26'd0, verdict}, {26'd0, e});
            chk("R9 syndrome", {26'd0, syndrome},
                (e == T2 || e == HY || e == T3) ? 32'h3 : 32'h0);
            chk("R10 read no strobe", {31'd0, reg_wr_en}, 32'd0);
        end

        // allowed write, all ones: masked load (R10, R11)
        @(negedge clk);
        set_ctx(11'b10_000_010_000);
        acc_req = 1; acc_write = 1; acc_wdata = 32'hFFFF_FFFF;
        #1 chk("R10 allowed write strobe", {31'd0, reg_wr_en}, 32'd1);
        @(negedge clk);
        chk("R11 masked load", reg_value, 32'h0000_0063);

        // secure write at level 1 refused
        set_ctx(11'b01_000_000_000);
        acc_wdata = 32'h0;
        #1 chk("R3 secure write no strobe", {31'd0, reg_wr_en}, 32'd0);
        @(negedge clk);
        chk("R10 refused write holds", reg_value, 32'h0000_0063);

        // allowed write at level 1
        set_ctx(11'b01_000_010_000);
        acc_wdata = 32'h0000_0021;
        @(negedge clk);
        chk("R10 second load", reg_value, 32'h0000_0021);

        // allowed read leaves register
        acc_write = 0; acc_wdata = 32'h0000_0042;
        @(negedge clk);
        chk("R10 read holds", reg_value, 32'h0000_0021);

        // idle write-flag cycle
        acc_req = 0; acc_write = 1;
        #1 chk("R10 idle no strobe", {31'd0, reg_wr_en}, 32'd0);
        @(negedge clk);
        chk("R10 idle holds", reg_value, 32'h0000_0021);

        // write hit by a 32-bit monitor trap at level 2
        acc_req = 1; acc_write = 1; acc_wdata = 32'h0;
        set_ctx(11'b10_001_011_001);
        #1 chk("R6 monitor trap verdict", {26'd0, verdict}, {26'd0, MO});
        @(negedge clk);
        chk("R10 trapped write holds", reg_value, 32'h0000_0021);

        // reset returns register to zero
        acc_req = 0;
        rst_n = 0;
        #1 chk("R11 reset clears", reg_value, 32'h0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        finish_run();
    end

endmodule